// File: doc/BRIEF.md
# Flag-Rule Arithmetic-Logic Unit

This block is the combinational arithmetic, logic and shift stage of a small accumulator machine. Each cycle it takes an operation code, a 16-bit accumulator word, an 8-bit second operand and the current condition flags. It returns a result word, the next flag nibble and a write-enable. The write-enable tells the surrounding core whether the result should be stored back.

Each operation applies its own rule to the four flags. A flag is either recomputed from the operation, forced to 0, forced to 1, or passed through unchanged. A decoder turns the operation code into that per-flag policy. A datapath computes the raw values and merges them under the policy.

Byte operations work on the low byte of the accumulator and return a zero-extended result. Word operations cover the shifts and the index step, and use the full 16 bits.

Top module: `alu_flagunit`

## Requirements
- R1: The flag nibble is ordered {N,Z,V,C} on bits 3..0. Operation codes are: CLR=0, INC=1, DEC=2, ADD=3, ADC=4, SUB=5, SBC=6, NEG=7, COM=8, AND=9, OR=10, XOR=11, BSET=12, BCLR=13, TST=14, CMP=15, BIT=16, LSR=17, ASR=18, ASL=19, ROR=20, ROL=21, LSRW=22, ASRW=23, ASLW=24, INCW=25, DECW=26. CLR returns 0 with flags 4'b0100 and write-enable 1.
- R2: ADD returns acc+oper; ADC also adds the incoming C. C is the carry out of bit 7. V is set when both operands share a sign that the result does not. N and Z come from the result.
- R3: SUB returns acc-oper; SBC also subtracts the incoming C. C is the borrow. V is set when the operands differ in sign and the result sign differs from acc. CMP computes the SUB flags and result with write-enable 0.
- R4: NEG returns 0-acc. C is 1 exactly when acc is nonzero. V is 1 exactly when acc is 0x80.
- R5: INC and DEC step the byte by one and keep C. V is set for INC of 0x7F and for DEC of 0x80.
- R6: AND, OR and XOR apply to the two operands. BSET returns acc|oper and BCLR returns acc&~oper. All five clear V, keep C and update N and Z.
- R7: COM returns ~acc, clears V and sets C.
- R8: TST returns acc, takes N and Z from it and clears V and C. BIT returns acc&oper, takes N and Z from it, clears V and keeps C. Both drive write-enable 0.
- R9: LSR shifts the byte right with 0 in. ASR shifts right and keeps bit 7. ASL shifts left with 0 in. The bit shifted out goes to C, and V equals N xor C.
- R10: ROR and ROL rotate the byte through C, with the old C entering at the vacated end. V equals N xor C.
- R11: LSRW, ASRW and ASLW apply the R9 rules to the full 16-bit accumulator, with N taken from bit 15.
- R12: INCW and DECW step the 16-bit word by one, update only Z and keep N, V and C.
- R13: Byte operations ignore accumulator bits 15..8 and return them as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 5 | Operation code (R1) |
| accIn | input | 16 | Accumulator or index word |
| operIn | input | 8 | Second operand or mask |
| flagsIn | input | 4 | Incoming {N,Z,V,C} |
| resultOut | output | 16 | Computed result |
| flagsOut | output | 4 | Updated {N,Z,V,C} |
| writeEn | output | 1 | Result should be stored |

## Verification
The bench builds the block with the default byte width of 8, so the word width is 16. At that width the signed boundaries 0x7F and 0x80 and the 16-bit carry wrap of the index step can be reached directly. Every byte value is swept through NEG and INC, which checks the C and V boundaries for all operands. A vector table covers each flag policy with the incoming flags set so that keep, clear and set can each be told apart.

// File: rtl/aluf_pkg.sv
package aluf_pkg;
  typedef enum logic [4:0] {
    OP_CLR  = 5'd0,  OP_INC  = 5'd1,  OP_DEC  = 5'd2,  OP_ADD  = 5'd3,
    OP_ADC  = 5'd4,  OP_SUB  = 5'd5,  OP_SBC  = 5'd6,  OP_NEG  = 5'd7,
    OP_COM  = 5'd8,  OP_AND  = 5'd9,  OP_OR   = 5'd10, OP_XOR  = 5'd11,
    OP_BSET = 5'd12, OP_BCLR = 5'd13, OP_TST  = 5'd14, OP_CMP  = 5'd15,
    OP_BIT  = 5'd16, OP_LSR  = 5'd17, OP_ASR  = 5'd18, OP_ASL  = 5'd19,
    OP_ROR  = 5'd20, OP_ROL  = 5'd21, OP_LSRW = 5'd22, OP_ASRW = 5'd23,
    OP_ASLW = 5'd24, OP_INCW = 5'd25, OP_DECW = 5'd26
  } op_e;

  typedef enum logic [1:0] {FM_KEEP, FM_CLR, FM_SET, FM_CALC} flagMode_e;

  typedef struct packed {
    flagMode_e nMode;
    flagMode_e zMode;
    flagMode_e vMode;
    flagMode_e cMode;
    logic      writeEn;
    logic      wideOp;
  } flagPolicy_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import aluf_pkg::*;
(
  input  op_e         opCode,
  output flagPolicy_t policy
);
  always_comb begin
    // unused codes: keep every flag, no write
    policy = '{nMode: FM_KEEP, zMode: FM_KEEP, vMode: FM_KEEP,
               cMode: FM_KEEP, writeEn: 1'b0, wideOp: 1'b0};
    case (opCode)
      OP_CLR:
        policy = '{FM_CALC, FM_CALC, FM_CLR, FM_CLR, 1'b1, 1'b0};
      OP_INC, OP_DEC:
        policy = '{FM_CALC, FM_CALC, FM_CALC, FM_KEEP, 1'b1, 1'b0};
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG,
      OP_LSR, OP_ASR, OP_ASL, OP_ROR, OP_ROL:
        policy = '{FM_CALC, FM_CALC, FM_CALC, FM_CALC, 1'b1, 1'b0};
      OP_COM:
        policy = '{FM_CALC, FM_CALC, FM_CLR, FM_SET, 1'b1, 1'b0};
      OP_AND, OP_OR, OP_XOR, OP_BSET, OP_BCLR:
        policy = '{FM_CALC, FM_CALC, FM_CLR, FM_KEEP, 1'b1, 1'b0};
      OP_TST:
        policy = '{FM_CALC, FM_CALC, FM_CLR, FM_CLR, 1'b0, 1'b0};
      OP_CMP:
        policy = '{FM_CALC, FM_CALC, FM_CALC, FM_CALC, 1'b0, 1'b0};
      OP_BIT:
        policy = '{FM_CALC, FM_CALC, FM_CLR, FM_KEEP, 1'b0, 1'b0};
      OP_LSRW, OP_ASRW, OP_ASLW:
        policy = '{FM_CALC, FM_CALC, FM_CALC, FM_CALC, 1'b1, 1'b1};
      OP_INCW, OP_DECW:
        policy = '{FM_KEEP, FM_CALC, FM_KEEP, FM_KEEP, 1'b1, 1'b1};
      default: ;
    endcase
  end

  always_comb begin
    if (!$isunknown(opCode)) begin
      // R8: compare-style operations never request a store
      assert_no_write_R8: assert (!((opCode == OP_CMP || opCode == OP_TST ||
                                     opCode == OP_BIT) && policy.writeEn));
    end
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import aluf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  op_e                 opCode,
  input  flagPolicy_t         policy,
  input  logic [2*BYTE_W-1:0] accIn,
  input  logic [BYTE_W-1:0]   operIn,
  input  logic [3:0]          flagsIn,
  output logic [2*BYTE_W-1:0] resultOut,
  output logic [3:0]          flagsOut
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0] SIGN_MIN = {1'b1, {(BYTE_W-1){1'b0}}};
  localparam logic [BYTE_W-1:0] SIGN_MAX = {1'b0, {(BYTE_W-1){1'b1}}};

  logic [BYTE_W-1:0] accLo;
  logic              carryIn;
  logic              addCin, subBin;
  logic [BYTE_W:0]   addExt, subExt;
  logic [BYTE_W-1:0] negRes;
  logic [BYTE_W-1:0] byteRes;
  logic [WORD_W-1:0] wideRes;
  logic              vCalc, cCalc, nCalc, zCalc;

  assign accLo   = accIn[BYTE_W-1:0];
  assign carryIn = flagsIn[FLAG_C];
  assign addCin  = (opCode == OP_ADC) & carryIn;
  assign subBin  = (opCode == OP_SBC) & carryIn;
  assign addExt  = {1'b0, accLo} + {1'b0, operIn} + {{BYTE_W{1'b0}}, addCin};
  assign subExt  = {1'b0, accLo} - {1'b0, operIn} - {{BYTE_W{1'b0}}, subBin};
  assign negRes  = {BYTE_W{1'b0}} - accLo;

  always_comb begin
    byteRes = accLo;
    wideRes = accIn;
    vCalc   = 1'b0;
    cCalc   = 1'b0;
    case (opCode)
      OP_CLR:  byteRes = '0;
      OP_INC: begin byteRes = accLo + 1'b1; vCalc = (accLo == SIGN_MAX); end
      OP_DEC: begin byteRes = accLo - 1'b1; vCalc = (accLo == SIGN_MIN); end
      OP_ADD, OP_ADC: begin
        byteRes = addExt[BYTE_W-1:0];
        cCalc   = addExt[BYTE_W];
        vCalc   = (accLo[BYTE_W-1] == operIn[BYTE_W-1]) &&
                  (addExt[BYTE_W-1] != accLo[BYTE_W-1]);
      end
      OP_SUB, OP_SBC, OP_CMP: begin
        byteRes = subExt[BYTE_W-1:0];
        cCalc   = subExt[BYTE_W];
        vCalc   = (accLo[BYTE_W-1] != operIn[BYTE_W-1]) &&
                  (subExt[BYTE_W-1] != accLo[BYTE_W-1]);
      end
      OP_NEG: begin
        byteRes = negRes;
        cCalc   = (accLo != '0);
        vCalc   = (accLo == SIGN_MIN);
      end
      OP_COM:  byteRes = ~accLo;
      OP_AND, OP_BIT: byteRes = accLo & operIn;
      OP_OR,  OP_BSET: byteRes = accLo | operIn;
      OP_XOR:  byteRes = accLo ^ operIn;
      OP_BCLR: byteRes = accLo & ~operIn;
      OP_TST:  byteRes = accLo;
      OP_LSR: begin
        byteRes = {1'b0, accLo[BYTE_W-1:1]};
        cCalc = accLo[0]; vCalc = accLo[0];
      end
      OP_ASR: begin
        byteRes = {accLo[BYTE_W-1], accLo[BYTE_W-1:1]};
        cCalc = accLo[0]; vCalc = accLo[BYTE_W-1] ^ accLo[0];
      end
      OP_ASL: begin
        byteRes = {accLo[BYTE_W-2:0], 1'b0};
        cCalc = accLo[BYTE_W-1]; vCalc = accLo[BYTE_W-2] ^ accLo[BYTE_W-1];
      end
      OP_ROR: begin
        byteRes = {carryIn, accLo[BYTE_W-1:1]};
        cCalc = accLo[0]; vCalc = carryIn ^ accLo[0];
      end
      OP_ROL: begin
        byteRes = {accLo[BYTE_W-2:0], carryIn};
        cCalc = accLo[BYTE_W-1]; vCalc = accLo[BYTE_W-2] ^ accLo[BYTE_W-1];
      end
      OP_LSRW: begin
        wideRes = {1'b0, accIn[WORD_W-1:1]};
        cCalc = accIn[0]; vCalc = accIn[0];
      end
      OP_ASRW: begin
        wideRes = {accIn[WORD_W-1], accIn[WORD_W-1:1]};
        cCalc = accIn[0]; vCalc = accIn[WORD_W-1] ^ accIn[0];
      end
      OP_ASLW: begin
        wideRes = {accIn[WORD_W-2:0], 1'b0};
        cCalc = accIn[WORD_W-1]; vCalc = accIn[WORD_W-2] ^ accIn[WORD_W-1];
      end
      OP_INCW: wideRes = accIn + 1'b1;
      OP_DECW: wideRes = accIn - 1'b1;
      default: ;
    endcase
  end

  assign resultOut = policy.wideOp ? wideRes : {{BYTE_W{1'b0}}, byteRes};
  assign nCalc     = policy.wideOp ? wideRes[WORD_W-1] : byteRes[BYTE_W-1];
  assign zCalc     = (resultOut == '0);

  function automatic logic pickFlag(flagMode_e mode, logic oldVal, logic newVal);
    case (mode)
      FM_CLR:  return 1'b0;
      FM_SET:  return 1'b1;
      FM_CALC: return newVal;
      default: return oldVal;
    endcase
  endfunction

  assign flagsOut[FLAG_N] = pickFlag(policy.nMode, flagsIn[FLAG_N], nCalc);
  assign flagsOut[FLAG_Z] = pickFlag(policy.zMode, flagsIn[FLAG_Z], zCalc);
  assign flagsOut[FLAG_V] = pickFlag(policy.vMode, flagsIn[FLAG_V], vCalc);
  assign flagsOut[FLAG_C] = pickFlag(policy.cMode, flagsIn[FLAG_C], cCalc);

  always_comb begin
    if (!$isunknown({opCode, accIn, operIn, flagsIn})) begin
      if (opCode == OP_CLR)
        assert_clear_flags_R1: assert (resultOut == '0 && flagsOut == 4'b0100);
      if (opCode == OP_NEG)
        assert_neg_sum_R4: assert (byteRes + accLo == '0);
      if (opCode == OP_ROR || opCode == OP_ROL)
        assert_rot_bits_R10: assert ($countones({byteRes, flagsOut[FLAG_C]}) ==
                                     $countones({accLo, carryIn}));
      if (opCode inside {OP_LSR, OP_ASR, OP_ASL, OP_ROR, OP_ROL,
                         OP_LSRW, OP_ASRW, OP_ASLW})
        assert_shift_v_R9: assert (flagsOut[FLAG_V] ==
                                   (flagsOut[FLAG_N] ^ flagsOut[FLAG_C]));
      if (opCode == OP_INCW || opCode == OP_DECW)
        assert_index_keep_R12: assert ({flagsOut[FLAG_N], flagsOut[FLAG_V], flagsOut[FLAG_C]} ==
                                       {flagsIn[FLAG_N], flagsIn[FLAG_V], flagsIn[FLAG_C]});
    end
  end
endmodule

// File: rtl/alu_flagunit.sv
module alu_flagunit
  import aluf_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [4:0]          opCode,
  input  logic [2*BYTE_W-1:0] accIn,
  input  logic [BYTE_W-1:0]   operIn,
  input  logic [3:0]          flagsIn,
  output logic [2*BYTE_W-1:0] resultOut,
  output logic [3:0]          flagsOut,
  output logic                writeEn
);
  op_e         opDec;
  flagPolicy_t policy;

  assign opDec   = op_e'(opCode);
  assign writeEn = policy.writeEn;

  alu_ctrl uCtrl (
    .opCode (opDec),
    .policy (policy)
  );

  alu_datapath #(.BYTE_W(BYTE_W)) uPath (
    .opCode    (opDec),
    .policy    (policy),
    .accIn     (accIn),
    .operIn    (operIn),
    .flagsIn   (flagsIn),
    .resultOut (resultOut),
    .flagsOut  (flagsOut)
  );
endmodule

// File: tb/tb_alu_flagunit.sv
module tb_alu_flagunit;
  import aluf_pkg::*;

  logic        clk = 1'b0;
  logic [4:0]  opCode = '0;
  logic [15:0] accIn = '0;
  logic [7:0]  operIn = '0;
  logic [3:0]  flagsIn = '0;
  logic [15:0] resultOut;
  logic [3:0]  flagsOut;
  logic        writeEn;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  alu_flagunit dut (.*);

  typedef struct packed {
    logic [4:0]  op;
    logic [15:0] acc;
    logic [7:0]  oper;
    logic [3:0]  fin;
    logic [15:0] expR;
    logic [3:0]  expF;
    logic        expW;
  } vec_t;

  localparam int NVEC = 35;
  localparam vec_t VECS [NVEC] = '{
    '{OP_CLR,  16'h0055, 8'h00, 4'hF, 16'h0000, 4'h4, 1'b1},
    '{OP_ADD,  16'h007F, 8'h01, 4'h0, 16'h0080, 4'hA, 1'b1},
    '{OP_ADD,  16'h00FF, 8'h01, 4'h0, 16'h0000, 4'h5, 1'b1},
    '{OP_ADC,  16'h0010, 8'h20, 4'h1, 16'h0031, 4'h0, 1'b1},
    '{OP_SUB,  16'h0080, 8'h01, 4'h0, 16'h007F, 4'h2, 1'b1},
    '{OP_SUB,  16'h0000, 8'h01, 4'h0, 16'h00FF, 4'h9, 1'b1},
    '{OP_SBC,  16'h0005, 8'h05, 4'h1, 16'h00FF, 4'h9, 1'b1},
    '{OP_CMP,  16'h0042, 8'h42, 4'h0, 16'h0000, 4'h4, 1'b0},
    '{OP_NEG,  16'h0080, 8'h00, 4'h0, 16'h0080, 4'hB, 1'b1},
    '{OP_NEG,  16'h0000, 8'h00, 4'hF, 16'h0000, 4'h4, 1'b1},
    '{OP_NEG,  16'h0001, 8'h00, 4'h0, 16'h00FF, 4'h9, 1'b1},
    '{OP_COM,  16'h000F, 8'h00, 4'h2, 16'h00F0, 4'h9, 1'b1},
    '{OP_AND,  16'h00F0, 8'h3C, 4'h1, 16'h0030, 4'h1, 1'b1},
    '{OP_OR,   16'h0080, 8'h01, 4'h2, 16'h0081, 4'h8, 1'b1},
    '{OP_XOR,  16'h00AA, 8'hAA, 4'h1, 16'h0000, 4'h5, 1'b1},
    '{OP_BSET, 16'h0001, 8'h80, 4'h0, 16'h0081, 4'h8, 1'b1},
    '{OP_BCLR, 16'h00FF, 8'h0F, 4'h1, 16'h00F0, 4'h9, 1'b1},
    '{OP_TST,  16'h0080, 8'h00, 4'h3, 16'h0080, 4'h8, 1'b0},
    '{OP_BIT,  16'h000F, 8'hF0, 4'h1, 16'h0000, 4'h5, 1'b0},
    '{OP_INC,  16'h007F, 8'h00, 4'h1, 16'h0080, 4'hB, 1'b1},
    '{OP_DEC,  16'h0080, 8'h00, 4'h0, 16'h007F, 4'h2, 1'b1},
    '{OP_DEC,  16'h0001, 8'h00, 4'h1, 16'h0000, 4'h5, 1'b1},
    '{OP_LSR,  16'h0081, 8'h00, 4'h0, 16'h0040, 4'h3, 1'b1},
    '{OP_ASR,  16'h0081, 8'h00, 4'h0, 16'h00C0, 4'h9, 1'b1},
    '{OP_ASL,  16'h0081, 8'h00, 4'h0, 16'h0002, 4'h3, 1'b1},
    '{OP_ROR,  16'h0002, 8'h00, 4'h1, 16'h0081, 4'hA, 1'b1},
    '{OP_ROL,  16'h0080, 8'h00, 4'h0, 16'h0000, 4'h7, 1'b1},
    '{OP_ROL,  16'h0080, 8'h00, 4'h1, 16'h0001, 4'h3, 1'b1},
    '{OP_LSRW, 16'h8001, 8'h00, 4'h0, 16'h4000, 4'h3, 1'b1},
    '{OP_ASRW, 16'h8000, 8'h00, 4'h0, 16'hC000, 4'hA, 1'b1},
    '{OP_ASLW, 16'h4001, 8'h00, 4'h0, 16'h8002, 4'hA, 1'b1},
    '{OP_INCW, 16'hFFFF, 8'h00, 4'hA, 16'h0000, 4'hE, 1'b1},
    '{OP_DECW, 16'h0002, 8'h00, 4'h5, 16'h0001, 4'h1, 1'b1},
    '{OP_INCW, 16'h0010, 8'h00, 4'h4, 16'h0011, 4'h0, 1'b1},
    '{OP_ADD,  16'hAB01, 8'h01, 4'h0, 16'h0002, 4'h0, 1'b1}
  };

  function automatic string reqName(logic [4:0] op, logic [15:0] acc);
    if (acc[15:8] != 8'h00 && op < 5'd22) return "R13";
    case (op)
      5'd0:  return "R1";
      5'd3, 5'd4: return "R2";
      5'd5, 5'd6, 5'd15: return "R3";
      5'd7:  return "R4";
      5'd1, 5'd2: return "R5";
      5'd9, 5'd10, 5'd11, 5'd12, 5'd13: return "R6";
      5'd8:  return "R7";
      5'd14, 5'd16: return "R8";
      5'd17, 5'd18, 5'd19: return "R9";
      5'd20, 5'd21: return "R10";
      5'd22, 5'd23, 5'd24: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [4:0] op, input logic [15:0] acc,
                       input logic [7:0] oper, input logic [3:0] fin);
    @(negedge clk);
    opCode = op; accIn = acc; operIn = oper; flagsIn = fin;
    #1;
  endtask

  task automatic expect3(input string req, input logic [15:0] expR,
                         input logic [3:0] expF, input logic expW);
    checks++;
    if (resultOut !== expR || flagsOut !== expF || writeEn !== expW) begin
      errors++;
      $display("FAIL %s op=%0d: got res=%h flags=%b we=%b, expected res=%h flags=%b we=%b",
               req, opCode, resultOut, flagsOut, writeEn, expR, expF, expW);
    end
  endtask

  initial begin
    // initial idle state: all-zero inputs decode to CLR (R1)
    #1;
    expect3("R1", 16'h0000, 4'b0100, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].op, VECS[i].acc, VECS[i].oper, VECS[i].fin);
      expect3(reqName(VECS[i].op, VECS[i].acc), VECS[i].expR, VECS[i].expF, VECS[i].expW);
    end

    // R4: every byte through NEG, upper accumulator bits set (R13)
    for (int v = 0; v < 256; v++) begin
      logic [7:0] r;
      r = 8'(256 - v);
      apply(OP_NEG, {8'h5A, 8'(v)}, 8'h00, 4'h0);
      expect3("R4", {8'h00, r}, {r[7], r == 8'h00, v == 128, v != 0}, 1'b1);
    end

    // R5: every byte through INC with C held at 1
    for (int v = 0; v < 256; v++) begin
      logic [7:0] r;
      r = 8'(v + 1);
      apply(OP_INC, {8'h00, 8'(v)}, 8'h00, 4'h1);
      expect3("R5", {8'h00, r}, {r[7], r == 8'h00, v == 127, 1'b1}, 1'b1);
    end

    // R6: logic ops keep C=0 and clear V with V set on entry
    apply(OP_AND, 16'h00FF, 8'h80, 4'h2);
    expect3("R6", 16'h0080, 4'b1000, 1'b1);

    // R12: DECW wrapping 0 -> FFFF keeps N,V,C from input
    apply(OP_DECW, 16'h0000, 8'h00, 4'h6);
    expect3("R12", 16'hFFFF, 4'b0010, 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: bench did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule